// File: doc/BRIEF.md
# Intra-Warp Lane-Set Co-Issue Allocator

Once the scheduler has picked a primary instruction for a warp and worked out which SIMD lane sets that instruction leaves unused, this allocator tries to fill the leftover sets from the same warp. The candidates come from the second half of that warp's instruction buffer, slot 2 then slot 3. Each of these slots holds an instruction from a divergent split of the warp. The allocator confirms that each candidate's split still exists in the split table and that its recorded pc has not moved. It then checks that the candidate needs the same functional-unit class as the primary. A candidate that passes gets a contiguous run of lane sets, starting at the next free set index, and its slot is released.

When a candidate has gone stale, the allocator tells the buffer to flush its second half and stops looking. This covers a split that is no longer valid, a split whose pc has moved, and a split that the co-issue update itself invalidated. All decisions for one scheduler cycle are made together and come out registered one clock later. The allocator also drives the register-reservation request. An inter-warp co-issue from elsewhere in the scheduler raises it. An intra-warp grant never does, because the primary instruction of the same warp has already reserved the destinations.

Top module: `simd_coissue_alloc`

## Requirements
- R1: No slot is granted and no flush is raised unless partitioning is enabled, a primary is valid, at least one set is free, and the primary class is neither none (code 0) nor memory (code 7). The 3-bit class codes are: none=0, SP=1, INT=2, DP=3, SFU=4, tensor=5, specialized=6, memory=7.
- R2: Slot 2 is examined before slot 3. Slot 3 is not examined once no sets remain after slot 2.
- R3: If the split-table lookup reports an examined slot's split invalid, half 1 is flushed, nothing is granted from that slot, and no later slot is examined.
- R4: If the split table's current pc for an examined slot differs from the slot's instruction pc, half 1 is flushed and examination stops.
- R5: A slot whose class differs from the primary's is skipped without a flush, and examination continues.
- R6: A slot needs ceil(popcount(mask) / SET_W) sets. A slot needing more sets than remain is skipped without a flush.
- R7: A granted slot receives the sets from the current next-free index onward. The remaining count drops by the sets used and the next-free index advances by the same amount. A second grant starts where the first one ended.
- R8: If a granted slot's split is reported invalid after the co-issue update, half 1 is flushed and no later slot is examined. The grant itself stands.
- R9: The reservation request is raised for an inter-warp co-issue and never by an intra-warp grant.
- R10: A slot that holds no valid instruction is skipped without a flush.
- R11: All outputs are registered. They reflect the inputs of the previous clock and are zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| part_en_i | input | 1 | Lane-set partitioning enabled |
| prim_valid_i | input | 1 | A primary instruction was chosen this cycle |
| prim_cls_i | input | 3 | Primary unit class |
| avail_i | input | CW | Free lane sets left by the primary |
| next_i | input | CW | First free set index |
| inter_gnt_i | input | 1 | An inter-warp co-issue was made this cycle |
| s2_valid_i | input | 1 | Slot 2 holds an instruction |
| s2_pc_i | input | PC_W | Slot 2 instruction pc |
| s2_sid_i | input | SID_W | Slot 2 split id |
| s2_cls_i | input | 3 | Slot 2 unit class |
| s2_mask_i | input | LANES | Slot 2 split mask |
| s2_tbl_ok_i | input | 1 | Split table: slot 2 split valid |
| s2_tbl_pc_i | input | PC_W | Split table: slot 2 split pc |
| s2_post_ok_i | input | 1 | Slot 2 split still valid after co-issue update |
| s3_valid_i | input | 1 | Slot 3 holds an instruction |
| s3_pc_i | input | PC_W | Slot 3 instruction pc |
| s3_sid_i | input | SID_W | Slot 3 split id |
| s3_cls_i | input | 3 | Slot 3 unit class |
| s3_mask_i | input | LANES | Slot 3 split mask |
| s3_tbl_ok_i | input | 1 | Split table: slot 3 split valid |
| s3_tbl_pc_i | input | PC_W | Split table: slot 3 split pc |
| s3_post_ok_i | input | 1 | Slot 3 split still valid after co-issue update |
| gnt_o | output | 2 | Grant and slot free, bit 0 slot 2, bit 1 slot 3 |
| s2_base_o | output | CW | First set given to slot 2 |
| s2_cnt_o | output | CW | Sets given to slot 2 |
| s2_gsid_o | output | SID_W | Split id co-issued from slot 2 |
| s3_base_o | output | CW | First set given to slot 3 |
| s3_cnt_o | output | CW | Sets given to slot 3 |
| s3_gsid_o | output | SID_W | Split id co-issued from slot 3 |
| flush_o | output | 1 | Flush buffer half 1 |
| sets_left_o | output | CW | Free sets after the grants |
| next_o | output | CW | Next free set index after the grants |
| rsv_o | output | 1 | Reserve destination registers |

## Verification
Every result of this block comes out exactly one clock after the inputs that cause it. This includes grants, set bases and counts, the flush, the updated set count and index, and the reservation request. The bench changes the inputs on a falling edge, waits for the next rising edge, and reads the outputs 1 ns later, so each check sees only the scenario it drove. Between scenarios the inputs return to an idle state, and some checks confirm that a skipped slot caused neither a grant nor a flush in that same sampled cycle.

// File: rtl/simd_coissue_alloc.sv
module simd_coissue_alloc #(
  parameter int NUM_SETS = 4,
  parameter int SET_W    = 8,
  parameter int LANES    = 32,
  parameter int PC_W     = 32,
  parameter int SID_W    = 4,
  localparam int CW = $clog2(NUM_SETS + 1),
  localparam int PW = $clog2(LANES + 1),
  localparam int AW = ((PW > CW) ? PW : CW) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             part_en_i,
  input  logic             prim_valid_i,
  input  logic [2:0]       prim_cls_i,
  input  logic [CW-1:0]    avail_i,
  input  logic [CW-1:0]    next_i,
  input  logic             inter_gnt_i,
  input  logic             s2_valid_i,
  input  logic [PC_W-1:0]  s2_pc_i,
  input  logic [SID_W-1:0] s2_sid_i,
  input  logic [2:0]       s2_cls_i,
  input  logic [LANES-1:0] s2_mask_i,
  input  logic             s2_tbl_ok_i,
  input  logic [PC_W-1:0]  s2_tbl_pc_i,
  input  logic             s2_post_ok_i,
  input  logic             s3_valid_i,
  input  logic [PC_W-1:0]  s3_pc_i,
  input  logic [SID_W-1:0] s3_sid_i,
  input  logic [2:0]       s3_cls_i,
  input  logic [LANES-1:0] s3_mask_i,
  input  logic             s3_tbl_ok_i,
  input  logic [PC_W-1:0]  s3_tbl_pc_i,
  input  logic             s3_post_ok_i,
  output logic [1:0]       gnt_o,
  output logic [CW-1:0]    s2_base_o,
  output logic [CW-1:0]    s2_cnt_o,
  output logic [SID_W-1:0] s2_gsid_o,
  output logic [CW-1:0]    s3_base_o,
  output logic [CW-1:0]    s3_cnt_o,
  output logic [SID_W-1:0] s3_gsid_o,
  output logic             flush_o,
  output logic [CW-1:0]    sets_left_o,
  output logic [CW-1:0]    next_o,
  output logic             rsv_o
);

  localparam logic [2:0] CLS_NONE = 3'd0;
  localparam logic [2:0] CLS_MEM  = 3'd7;

  function automatic logic [AW-1:0] sets_for(input logic [LANES-1:0] m);
    logic [AW-1:0] n;
    n = '0;
    for (int i = 0; i < LANES; i++) n = n + AW'(m[i]);
    return (n + AW'(SET_W - 1)) / AW'(SET_W);
  endfunction

  logic          act;
  logic [AW-1:0] av0, nx0, av1, nx1, av2, nx2;
  logic [AW-1:0] s2_need, s3_need;
  logic          s2_chk, s2_stale, s2_fit, s2_kill;
  logic          s3_chk, s3_stale, s3_fit, s3_kill;

  assign act = part_en_i && prim_valid_i && (avail_i != '0) &&
               (prim_cls_i != CLS_NONE) && (prim_cls_i != CLS_MEM);
  assign av0 = AW'(avail_i);
  assign nx0 = AW'(next_i);

  assign s2_need  = sets_for(s2_mask_i);
  assign s2_chk   = act && s2_valid_i;
  assign s2_stale = s2_chk && (!s2_tbl_ok_i || (s2_tbl_pc_i != s2_pc_i));
  assign s2_fit   = s2_chk && !s2_stale && (s2_cls_i == prim_cls_i) && (s2_need <= av0);
  assign s2_kill  = s2_stale || (s2_fit && !s2_post_ok_i);
  assign av1      = s2_fit ? av0 - s2_need : av0;
  assign nx1      = s2_fit ? nx0 + s2_need : nx0;

  assign s3_need  = sets_for(s3_mask_i);
  assign s3_chk   = act && !s2_kill && (av1 != '0) && s3_valid_i;
  assign s3_stale = s3_chk && (!s3_tbl_ok_i || (s3_tbl_pc_i != s3_pc_i));
  assign s3_fit   = s3_chk && !s3_stale && (s3_cls_i == prim_cls_i) && (s3_need <= av1);
  assign s3_kill  = s3_stale || (s3_fit && !s3_post_ok_i);
  assign av2      = s3_fit ? av1 - s3_need : av1;
  assign nx2      = s3_fit ? nx1 + s3_need : nx1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gnt_o       <= '0;
      s2_base_o   <= '0;
      s2_cnt_o    <= '0;
      s2_gsid_o   <= '0;
      s3_base_o   <= '0;
      s3_cnt_o    <= '0;
      s3_gsid_o   <= '0;
      flush_o     <= 1'b0;
      sets_left_o <= '0;
      next_o      <= '0;
      rsv_o       <= 1'b0;
    end else begin
      gnt_o       <= {s3_fit, s2_fit};
      s2_base_o   <= s2_fit ? CW'(nx0) : '0;
      s2_cnt_o    <= s2_fit ? CW'(s2_need) : '0;
      s2_gsid_o   <= s2_fit ? s2_sid_i : '0;
      s3_base_o   <= s3_fit ? CW'(nx1) : '0;
      s3_cnt_o    <= s3_fit ? CW'(s3_need) : '0;
      s3_gsid_o   <= s3_fit ? s3_sid_i : '0;
      flush_o     <= s2_kill || s3_kill;
      sets_left_o <= CW'(av2);
      next_o      <= CW'(nx2);
      rsv_o       <= inter_gnt_i;
    end
  end

  AST_GATE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!part_en_i || !prim_valid_i || avail_i == '0 || prim_cls_i == CLS_NONE || prim_cls_i == CLS_MEM)
    |=> (gnt_o == 2'b00 && !flush_o)); // R1

  AST_EXHAUST_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_o[0] && AW'(s2_cnt_o) == AW'($past(avail_i))) |-> !gnt_o[1]); // R2

  AST_STALE_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (act && s2_valid_i && !s2_tbl_ok_i) |=> (flush_o && gnt_o == 2'b00)); // R3

  AST_CLASS_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    (act && s2_valid_i && s2_tbl_ok_i && s2_tbl_pc_i == s2_pc_i && s2_cls_i != prim_cls_i)
    |=> !gnt_o[0]); // R5

  AST_FIT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_o[0] |-> (s2_cnt_o <= $past(avail_i))); // R6

  AST_CONTIG: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_o == 2'b11) |-> (AW'(s3_base_o) == AW'(s2_base_o) + AW'(s2_cnt_o))); // R7

  AST_NO_OVERCOMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_o != 2'b00) |-> (sets_left_o <= $past(avail_i))); // R7

  AST_NO_INTRA_RSV: assert property (@(posedge clk) disable iff (!rst_n)
    ((gnt_o != 2'b00) && !$past(inter_gnt_i)) |-> !rsv_o); // R9

endmodule

// File: tb/simd_coissue_alloc_tb.sv
module simd_coissue_alloc_tb;
  localparam int CW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic part_en_i, prim_valid_i, inter_gnt_i;
  logic [2:0] prim_cls_i;
  logic [CW-1:0] avail_i, next_i;
  logic s2_valid_i, s2_tbl_ok_i, s2_post_ok_i;
  logic [31:0] s2_pc_i, s2_tbl_pc_i, s2_mask_i;
  logic [3:0] s2_sid_i;
  logic [2:0] s2_cls_i;
  logic s3_valid_i, s3_tbl_ok_i, s3_post_ok_i;
  logic [31:0] s3_pc_i, s3_tbl_pc_i, s3_mask_i;
  logic [3:0] s3_sid_i;
  logic [2:0] s3_cls_i;
  logic [1:0] gnt_o;
  logic [CW-1:0] s2_base_o, s2_cnt_o, s3_base_o, s3_cnt_o, sets_left_o, next_o;
  logic [3:0] s2_gsid_o, s3_gsid_o;
  logic flush_o, rsv_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  simd_coissue_alloc u_dut (
    .clk(clk), .rst_n(rst_n), .part_en_i(part_en_i), .prim_valid_i(prim_valid_i),
    .prim_cls_i(prim_cls_i), .avail_i(avail_i), .next_i(next_i), .inter_gnt_i(inter_gnt_i),
    .s2_valid_i(s2_valid_i), .s2_pc_i(s2_pc_i), .s2_sid_i(s2_sid_i), .s2_cls_i(s2_cls_i),
    .s2_mask_i(s2_mask_i), .s2_tbl_ok_i(s2_tbl_ok_i), .s2_tbl_pc_i(s2_tbl_pc_i),
    .s2_post_ok_i(s2_post_ok_i),
    .s3_valid_i(s3_valid_i), .s3_pc_i(s3_pc_i), .s3_sid_i(s3_sid_i), .s3_cls_i(s3_cls_i),
    .s3_mask_i(s3_mask_i), .s3_tbl_ok_i(s3_tbl_ok_i), .s3_tbl_pc_i(s3_tbl_pc_i),
    .s3_post_ok_i(s3_post_ok_i),
    .gnt_o(gnt_o), .s2_base_o(s2_base_o), .s2_cnt_o(s2_cnt_o), .s2_gsid_o(s2_gsid_o),
    .s3_base_o(s3_base_o), .s3_cnt_o(s3_cnt_o), .s3_gsid_o(s3_gsid_o),
    .flush_o(flush_o), .sets_left_o(sets_left_o), .next_o(next_o), .rsv_o(rsv_o)
  );

  function automatic logic [31:0] lanes(input int n);
    return (n >= 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle();
    part_en_i = 1'b0; prim_valid_i = 1'b0; prim_cls_i = 3'd0; inter_gnt_i = 1'b0;
    avail_i = '0; next_i = '0;
    s2_valid_i = 1'b0; s2_pc_i = 32'h100; s2_tbl_pc_i = 32'h100; s2_sid_i = 4'd2;
    s2_cls_i = 3'd1; s2_mask_i = '0; s2_tbl_ok_i = 1'b1; s2_post_ok_i = 1'b1;
    s3_valid_i = 1'b0; s3_pc_i = 32'h200; s3_tbl_pc_i = 32'h200; s3_sid_i = 4'd5;
    s3_cls_i = 3'd1; s3_mask_i = '0; s3_tbl_ok_i = 1'b1; s3_post_ok_i = 1'b1;
  endtask

  task automatic setup(input int av, input int nx, input int n2, input int n3);
    idle();
    part_en_i = 1'b1; prim_valid_i = 1'b1; prim_cls_i = 3'd1;
    avail_i = CW'(av); next_i = CW'(nx);
    s2_valid_i = 1'b1; s2_mask_i = lanes(n2);
    s3_valid_i = 1'b1; s3_mask_i = lanes(n3);
  endtask

  task automatic step();
    @(posedge clk); #1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R11 reset gnt", gnt_o, 0);
    chk("R11 reset flush", flush_o, 0);
    chk("R11 reset rsv", rsv_o, 0);
  endtask

  task automatic t_gate();
    setup(4, 0, 8, 8); part_en_i = 1'b0;
    @(posedge clk); #1;
    chk("R1 part off gnt", gnt_o, 0); chk("R1 part off flush", flush_o, 0);
    @(negedge clk);
    setup(4, 0, 8, 8); prim_cls_i = 3'd7; s2_cls_i = 3'd7; s3_cls_i = 3'd7;
    @(posedge clk); #1; chk("R1 mem class gnt", gnt_o, 0);
    @(negedge clk);
    setup(4, 0, 8, 8); prim_cls_i = 3'd0; s2_cls_i = 3'd0; s3_cls_i = 3'd0;
    @(posedge clk); #1; chk("R1 none class gnt", gnt_o, 0);
    @(negedge clk);
    setup(0, 0, 8, 8); s2_tbl_ok_i = 1'b0;
    @(posedge clk); #1; chk("R1 no sets gnt", gnt_o, 0); chk("R1 no sets flush", flush_o, 0);
    @(negedge clk);
    setup(4, 0, 8, 8); prim_valid_i = 1'b0;
    @(posedge clk); #1; chk("R1 no primary gnt", gnt_o, 0);
    @(negedge clk);
  endtask

  task automatic t_both();
    setup(3, 1, 8, 9);
    @(posedge clk); #1;
    chk("R7 both gnt", gnt_o, 3);
    chk("R7 s2 base", s2_base_o, 1); chk("R6 s2 cnt", s2_cnt_o, 1);
    chk("R7 s3 base", s3_base_o, 2); chk("R6 s3 cnt ceil", s3_cnt_o, 2);
    chk("R7 left", sets_left_o, 0); chk("R7 next", next_o, 4);
    chk("R7 s3 sid", s3_gsid_o, 5); chk("R7 flush", flush_o, 0);
    @(negedge clk);
  endtask

  task automatic t_stale();
    setup(4, 0, 8, 8); s2_tbl_ok_i = 1'b0;
    @(posedge clk); #1;
    chk("R3 flush", flush_o, 1); chk("R3 gnt", gnt_o, 0); chk("R3 left", sets_left_o, 4);
    @(negedge clk);
  endtask

  task automatic t_pc();
    setup(4, 0, 8, 8); s3_tbl_pc_i = 32'h204;
    @(posedge clk); #1;
    chk("R4 gnt", gnt_o, 1); chk("R4 flush", flush_o, 1);
    chk("R4 left", sets_left_o, 3); chk("R4 next", next_o, 1);
    @(negedge clk);
    setup(4, 0, 8, 8); s2_tbl_pc_i = 32'h0FC;
    @(posedge clk); #1;
    chk("R4 s2 pc gnt", gnt_o, 0); chk("R4 s2 pc flush", flush_o, 1);
    @(negedge clk);
  endtask

  task automatic t_class();
    setup(4, 0, 8, 8); s2_cls_i = 3'd3;
    @(posedge clk); #1;
    chk("R5 gnt", gnt_o, 2); chk("R5 flush", flush_o, 0);
    chk("R5 s3 base", s3_base_o, 0); chk("R5 left", sets_left_o, 3);
    @(negedge clk);
  endtask

  task automatic t_fit();
    setup(2, 2, 17, 1);
    @(posedge clk); #1;
    chk("R6 too big gnt", gnt_o, 2); chk("R6 too big flush", flush_o, 0);
    chk("R6 s3 base", s3_base_o, 2); chk("R6 s3 cnt", s3_cnt_o, 1);
    chk("R6 left", sets_left_o, 1); chk("R6 next", next_o, 3);
    @(negedge clk);
    setup(2, 0, 16, 8);
    @(posedge clk); #1;
    chk("R6 exact gnt", gnt_o, 1); chk("R6 exact cnt", s2_cnt_o, 2);
    chk("R2 exhausted left", sets_left_o, 0);
    @(negedge clk);
  endtask

  task automatic t_exhaust();
    setup(1, 3, 8, 8); s3_tbl_ok_i = 1'b0;
    @(posedge clk); #1;
    chk("R2 gnt", gnt_o, 1); chk("R2 no flush", flush_o, 0); chk("R2 base", s2_base_o, 3);
    @(negedge clk);
  endtask

  task automatic t_post();
    setup(4, 0, 8, 8); s2_post_ok_i = 1'b0;
    @(posedge clk); #1;
    chk("R8 gnt", gnt_o, 1); chk("R8 flush", flush_o, 1); chk("R8 left", sets_left_o, 3);
    @(negedge clk);
  endtask

  task automatic t_empty();
    setup(4, 1, 8, 24); s2_valid_i = 1'b0; s2_tbl_ok_i = 1'b0;
    @(posedge clk); #1;
    chk("R10 gnt", gnt_o, 2); chk("R10 flush", flush_o, 0);
    chk("R10 base", s3_base_o, 1); chk("R10 cnt", s3_cnt_o, 3);
    @(negedge clk);
  endtask

  task automatic t_rsv();
    idle(); inter_gnt_i = 1'b1;
    @(posedge clk); #1; chk("R9 inter rsv", rsv_o, 1);
    @(negedge clk);
    setup(4, 0, 8, 8);
    @(posedge clk); #1;
    chk("R9 intra gnt", gnt_o, 3); chk("R9 intra no rsv", rsv_o, 0);
    @(negedge clk);
  endtask

  initial begin
    idle();
    repeat (3) @(posedge clk);
    #1 t_reset();
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    t_gate();
    t_both();
    t_stale();
    t_pc();
    t_class();
    t_fit();
    t_exhaust();
    t_post();
    t_empty();
    t_rsv();
    idle();
    step();
    chk("R11 idle after", gnt_o, 0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      total++; bad++;
      $display("FAIL R11 watchdog: got %0d expected %0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule